// File: doc/BRIEF.md
# Dual-Address Remapped Load Cache

This block is a direct-mapped, read-only cache that serves loads. Each load carries two addresses. The placement address selects the set. The real address supplies the tag compare, the word select and the line fill. Software can therefore move a data stream into other sets without touching the memory layout. A placement address only has to yield sensible index bits: it is never sent to memory, so it need not point at real data. A plain load drives the same value on both address inputs, and the block then behaves as an ordinary direct-mapped cache.

A hit returns its word one cycle after the request is accepted. Remapping does not lengthen that path. On a miss the block raises one line-aligned request on a simple request/response memory port. It writes the returned beats into the set chosen by the placement address, marks the line valid and then returns the requested word. Two counters report accepted hits and misses, so interference between streams can be measured. The default geometry is 16 KB with 32-byte lines (512 sets of eight 32-bit words).

Top module: `twin_cache`

## Requirements
- R1: The set index is taken from placement address bits [13:5] (default geometry), and the real address plays no part in choosing the set. One real line may be resident in two sets at the same time, and both copies hit.
- R2: The stored tag is the whole real address above the line offset, bits [31:5]. A lookup hits only when that set is valid and its tag equals the real address bits [31:5]. The returned word is selected by real address bits [4:2].
- R3: A miss issues exactly one memory request, on address `real & ~31`. The placement address never appears on the memory port.
- R4: After a hit is accepted, `rsp_valid_o` is high on the next cycle and `rsp_data_o` holds the word stored at the real address.
- R5: A fill takes one beat per word, in ascending word order from the line base. The response follows the last beat and carries the requested word. After the fill, the line hits.
- R6: From the cycle a miss is accepted until its response, `req_ready_o` is low and no request is accepted.
- R7: While `rst_ni` is low, every line is invalidated and both counters are cleared. Out of reset, `req_ready_o` is 1, and `rsp_valid_o` and `mem_req_valid_o` are 0.
- R8: Each accepted request adds one to `hit_count_o` or one to `miss_count_o`, never to both.
- R9: Two plain streams whose bases differ by a multiple of 16 KB miss on every interleaved access. Offsetting one stream's placement address by 32 bytes leaves only one miss per line per stream.
- R10: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request stays valid and its address stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Load request valid |
| req_ready_o | output | 1 | Block can accept a load |
| req_map_addr_i | input | 32 | Placement address (index bits only) |
| req_real_addr_i | input | 32 | Real byte address of the data |
| rsp_valid_o | output | 1 | Load data valid, one-cycle pulse |
| rsp_data_o | output | 32 | Load data |
| mem_req_valid_o | output | 1 | Line fetch request valid |
| mem_req_ready_i | input | 1 | Memory accepts the line fetch |
| mem_req_addr_o | output | 32 | Line-aligned real address |
| mem_rsp_valid_i | input | 1 | Fill beat valid |
| mem_rsp_data_i | input | 32 | Fill beat data |
| hit_count_o | output | 32 | Accepted hits since reset |
| miss_count_o | output | 32 | Accepted misses since reset |

## Verification
A wrong index source or a truncated tag shows up on the very next access to a shared set. It appears as an unexpected memory request or as a missing one, and the placement and real address pairs are chosen to separate the two cases. A fill beat written to the wrong word, or a stale captured word, corrupts the data seen either in the response that ends the fill or in the first hit to that line. A lost valid bit or a lost reset shows at once as an extra miss. The two conflict runs compare the counters against exact totals, so a single misplaced line changes the count.

// File: rtl/twin_cache_pkg.sv
package twin_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_FILL = 2'd2
  } state_e;
endpackage

// File: rtl/twin_cache_tags.sv
module twin_cache_tags #(
  parameter int SETS  = 512,
  parameter int IDX_W = 9,
  parameter int TAG_W = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic             hit_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  logic [TAG_W-1:0] tag_mem [SETS];
  logic [SETS-1:0]  valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_mem[wr_idx_i] <= wr_tag_i;
  end

  assign hit_o = valid_q[rd_idx_i] && (tag_mem[rd_idx_i] == rd_tag_i);
endmodule

// File: rtl/twin_cache_data.sv
module twin_cache_data #(
  parameter int SETS   = 512,
  parameter int WORDS  = 8,
  parameter int IDX_W  = 9,
  parameter int WSEL_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [WSEL_W-1:0] rd_word_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WSEL_W-1:0] wr_word_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int DEPTH = SETS * WORDS;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[{wr_idx_i, wr_word_i}] <= wr_data_i;
  end

  assign rd_data_o = mem[{rd_idx_i, rd_word_i}];
endmodule

// File: rtl/twin_cache_ctrl.sv
module twin_cache_ctrl
  import twin_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  parameter int IDX_W  = 9,
  parameter int WSEL_W = 3,
  parameter int TAG_W  = 27,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [TAG_W-1:0]  line_i,
  input  logic [WSEL_W-1:0] wsel_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i,
  output logic              data_we_o,
  output logic [IDX_W-1:0]  fill_idx_o,
  output logic [WSEL_W-1:0] fill_word_o,
  output logic              tag_we_o,
  output logic [TAG_W-1:0]  fill_tag_o,
  output logic [CNT_W-1:0]  hit_count_o,
  output logic [CNT_W-1:0]  miss_count_o
);
  localparam int OFF_W = ADDR_W - TAG_W;
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

  state_e            state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  line_q;
  logic [WSEL_W-1:0] wsel_q;
  logic [WSEL_W-1:0] beat_q;
  logic [DATA_W-1:0] word_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic [CNT_W-1:0]  hit_cnt_q;
  logic [CNT_W-1:0]  miss_cnt_q;

  logic accept;
  logic beat;
  logic last_beat;

  assign accept    = req_valid_i && (state_q == ST_IDLE);
  assign beat      = (state_q == ST_FILL) && mem_rsp_valid_i;
  assign last_beat = beat && (beat_q == LAST_BEAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      line_q      <= '0;
      wsel_q      <= '0;
      beat_q      <= '0;
      word_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      hit_cnt_q   <= '0;
      miss_cnt_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (hit_i) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= rd_data_i;
              hit_cnt_q   <= hit_cnt_q + 1'b1;
            end else begin
              miss_cnt_q <= miss_cnt_q + 1'b1;
              idx_q      <= idx_i;
              line_q     <= line_i;
              wsel_q     <= wsel_i;
              state_q    <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready_i) begin
            beat_q  <= '0;
            state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (beat) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == wsel_q) word_q <= mem_rsp_data_i;
            if (last_beat) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= (beat_q == wsel_q) ? mem_rsp_data_i : word_q;
              state_q     <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign rsp_valid_o     = rsp_valid_q;
  assign rsp_data_o      = rsp_data_q;
  assign mem_req_valid_o = (state_q == ST_REQ);
  assign mem_req_addr_o  = {line_q, {OFF_W{1'b0}}};
  assign data_we_o       = beat;
  assign fill_idx_o      = idx_q;
  assign fill_word_o     = beat_q;
  assign tag_we_o        = last_beat;
  assign fill_tag_o      = line_q;
  assign hit_count_o     = hit_cnt_q;
  assign miss_count_o    = miss_cnt_q;
endmodule

// File: rtl/twin_cache.sv
module twin_cache #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CACHE_BYTES = 16384,
  parameter int LINE_BYTES  = 32,
  parameter int CNT_W       = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_map_addr_i,
  input  logic [ADDR_W-1:0] req_real_addr_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i,
  output logic [CNT_W-1:0]  hit_count_o,
  output logic [CNT_W-1:0]  miss_count_o
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int WORDS      = LINE_BYTES / WORD_BYTES;
  localparam int SETS       = CACHE_BYTES / LINE_BYTES;
  localparam int BYTE_W     = $clog2(WORD_BYTES);
  localparam int WSEL_W     = $clog2(WORDS);
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int IDX_W      = $clog2(SETS);
  localparam int TAG_W      = ADDR_W - OFF_W;

  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_line;
  logic [WSEL_W-1:0] lk_wsel;
  logic              lk_hit;
  logic [DATA_W-1:0] lk_data;

  logic              data_we;
  logic              tag_we;
  logic [IDX_W-1:0]  fill_idx;
  logic [WSEL_W-1:0] fill_word;
  logic [TAG_W-1:0]  fill_tag;

  // placement address gives only the set; everything else comes from the real address
  assign lk_idx  = req_map_addr_i[OFF_W +: IDX_W];
  assign lk_line = req_real_addr_i[ADDR_W-1:OFF_W];
  assign lk_wsel = req_real_addr_i[BYTE_W +: WSEL_W];

  logic unused_addr_bits;
  assign unused_addr_bits = ^{req_map_addr_i[OFF_W-1:0],
                              req_map_addr_i[ADDR_W-1:OFF_W+IDX_W],
                              req_real_addr_i[BYTE_W-1:0]};

  twin_cache_tags #(
    .SETS (SETS),
    .IDX_W(IDX_W),
    .TAG_W(TAG_W)
  ) u_tags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_idx_i(lk_idx),
    .rd_tag_i(lk_line),
    .hit_o   (lk_hit),
    .wr_en_i (tag_we),
    .wr_idx_i(fill_idx),
    .wr_tag_i(fill_tag)
  );

  twin_cache_data #(
    .SETS  (SETS),
    .WORDS (WORDS),
    .IDX_W (IDX_W),
    .WSEL_W(WSEL_W),
    .DATA_W(DATA_W)
  ) u_data (
    .clk_i    (clk_i),
    .rd_idx_i (lk_idx),
    .rd_word_i(lk_wsel),
    .rd_data_o(lk_data),
    .wr_en_i  (data_we),
    .wr_idx_i (fill_idx),
    .wr_word_i(fill_word),
    .wr_data_i(mem_rsp_data_i)
  );

  twin_cache_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .WORDS (WORDS),
    .IDX_W (IDX_W),
    .WSEL_W(WSEL_W),
    .TAG_W (TAG_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_ready_o    (req_ready_o),
    .idx_i          (lk_idx),
    .line_i         (lk_line),
    .wsel_i         (lk_wsel),
    .hit_i          (lk_hit),
    .rd_data_i      (lk_data),
    .rsp_valid_o    (rsp_valid_o),
    .rsp_data_o     (rsp_data_o),
    .mem_req_valid_o(mem_req_valid_o),
    .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o (mem_req_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i (mem_rsp_data_i),
    .data_we_o      (data_we),
    .fill_idx_o     (fill_idx),
    .fill_word_o    (fill_word),
    .tag_we_o       (tag_we),
    .fill_tag_o     (fill_tag),
    .hit_count_o    (hit_count_o),
    .miss_count_o   (miss_count_o)
  );
endmodule

// File: rtl/twin_cache_chk.sv
module twin_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic [CNT_W-1:0]  hit_count_o,
  input logic [CNT_W-1:0]  miss_count_o
);
  // R10
  mem_req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  // R6
  busy_no_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);

  // R4
  accept_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (rsp_valid_o || mem_req_valid_o));

  // R8
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=>
      ((hit_count_o + miss_count_o) == CNT_W'($past(hit_count_o + miss_count_o) + 1'b1)));

  // R5
  rsp_then_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o);
endmodule

bind twin_cache twin_cache_chk #(
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W)
) u_twin_cache_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .rsp_valid_o    (rsp_valid_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_req_addr_o (mem_req_addr_o),
  .hit_count_o    (hit_count_o),
  .miss_count_o   (miss_count_o)
);

// File: tb/twin_cache_bench.sv
`timescale 1ns/1ps
module twin_cache_bench;
  localparam int WORDS = 8;
  localparam int NVEC  = 14;

  // {map addr, real addr, expect miss, memory stall cycles}
  localparam logic [66:0] VEC [NVEC] = '{
    {32'h0000_1000, 32'h0000_1000, 1'b1, 2'd0},
    {32'h0000_1004, 32'h0000_1004, 1'b0, 2'd0},
    {32'h0000_101C, 32'h0000_101C, 1'b0, 2'd0},
    {32'h0000_5000, 32'h0000_5000, 1'b1, 2'd2},
    {32'h0000_1000, 32'h0000_1000, 1'b1, 2'd0},
    {32'h0000_5020, 32'h0000_5000, 1'b1, 2'd1},
    {32'h0000_5020, 32'h0000_5008, 1'b0, 2'd0},
    {32'h0000_1008, 32'h0000_1008, 1'b0, 2'd0},
    {32'h0000_1020, 32'h0000_5004, 1'b0, 2'd0},
    {32'h0000_1020, 32'h0000_1020, 1'b1, 2'd3},
    {32'h0000_5020, 32'h0000_5000, 1'b1, 2'd0},
    {32'h0000_0000, 32'h0000_5010, 1'b1, 2'd1},
    {32'h0000_0004, 32'h0000_5014, 1'b0, 2'd0},
    {32'h0000_5020, 32'h0000_501C, 1'b0, 2'd0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_map_addr_i = '0;
  logic [31:0] req_real_addr_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_data_o;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic [31:0] hit_count_o;
  logic [31:0] miss_count_o;

  int checks = 0;
  int failures = 0;

  logic [31:0] l_data;
  logic [31:0] l_maddr;
  bit          l_miss;
  int          l_lat;
  int          l_nreq;
  bit          l_busy_bad;
  bit          l_hold_bad;

  always #4 clk_i = ~clk_i;

  twin_cache u_twin_cache (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_ready_o    (req_ready_o),
    .req_map_addr_i (req_map_addr_i),
    .req_real_addr_i(req_real_addr_i),
    .rsp_valid_o    (rsp_valid_o),
    .rsp_data_o     (rsp_data_o),
    .mem_req_valid_o(mem_req_valid_o),
    .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o (mem_req_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i (mem_rsp_data_i),
    .hit_count_o    (hit_count_o),
    .miss_count_o   (miss_count_o)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'hC35A, a[31:16] ^ a[15:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic do_load(input logic [31:0] m, input logic [31:0] r, input int stall);
    int cyc;
    bit done;
    @(negedge clk_i);
    req_valid_i     = 1'b1;
    req_map_addr_i  = m;
    req_real_addr_i = r;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    cyc = 1; done = 0; l_miss = 0; l_nreq = 0; l_busy_bad = 0; l_hold_bad = 0;
    l_data = '0; l_maddr = '0; l_lat = 0;
    while (!done) begin
      if (rsp_valid_o) begin
        l_data = rsp_data_o;
        l_lat  = cyc;
        done   = 1;
      end else if (mem_req_valid_o) begin
        l_miss = 1;
        l_nreq++;
        l_maddr = mem_req_addr_o;
        if (req_ready_o) l_busy_bad = 1;
        for (int s = 0; s < stall; s++) begin
          @(negedge clk_i); cyc++;
          if (!mem_req_valid_o || mem_req_addr_o != l_maddr) l_hold_bad = 1;
        end
        mem_req_ready_i = 1'b1;
        @(negedge clk_i); cyc++;
        mem_req_ready_i = 1'b0;
        for (int b = 0; b < WORDS; b++) begin
          if (req_ready_o) l_busy_bad = 1;
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i  = mem_word(l_maddr + 32'(4 * b));
          @(negedge clk_i); cyc++;
          mem_rsp_valid_i = 1'b0;
          if (stall > 0 && b < WORDS - 1) begin
            @(negedge clk_i); cyc++;
          end
        end
      end else begin
        @(negedge clk_i); cyc++;
      end
      if (cyc > 200) begin
        check(1'b0, "R4 response timeout", 32'(cyc), 32'd0);
        done = 1;
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int exp_hits;
    int exp_miss;
    do_reset();
    @(negedge clk_i);
    // R7 reset state
    check(req_ready_o == 1'b1, "R7 ready after reset", 32'(req_ready_o), 32'd1);
    check(rsp_valid_o == 1'b0, "R7 rsp idle after reset", 32'(rsp_valid_o), 32'd0);
    check(mem_req_valid_o == 1'b0, "R7 mem idle after reset", 32'(mem_req_valid_o), 32'd0);
    check(hit_count_o == 0 && miss_count_o == 0, "R7 counters cleared",
          hit_count_o + miss_count_o, 32'd0);

    exp_hits = 0; exp_miss = 0;
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] m, r;
      bit em;
      int st;
      m  = VEC[i][66:35];
      r  = VEC[i][34:3];
      em = VEC[i][2];
      st = int'(VEC[i][1:0]);
      do_load(m, r, st);
      if (em) exp_miss++; else exp_hits++;
      // R1 R2: hit/miss outcome set by placement index and full real tag
      check(l_miss == em, "R1/R2 hit-miss outcome", 32'(l_miss), 32'(em));
      // R4 R5: returned word from the real address
      check(l_data == mem_word({r[31:2], 2'b00}), "R4/R5 load data", l_data,
            mem_word({r[31:2], 2'b00}));
      if (em) begin
        // R3
        check(l_maddr == {r[31:5], 5'b0}, "R3 fill address is real line", l_maddr,
              {r[31:5], 5'b0});
        check(l_nreq == 1, "R3 single line request", 32'(l_nreq), 32'd1);
        // R6
        check(!l_busy_bad, "R6 ready low during fill", 32'(l_busy_bad), 32'd0);
        // R10
        check(!l_hold_bad, "R10 request held under stall", 32'(l_hold_bad), 32'd0);
      end else begin
        // R4
        check(l_lat == 1, "R4 hit latency", 32'(l_lat), 32'd1);
      end
    end
    // R8
    check(hit_count_o == 32'(exp_hits), "R8 hit counter", hit_count_o, 32'(exp_hits));
    check(miss_count_o == 32'(exp_miss), "R8 miss counter", miss_count_o, 32'(exp_miss));

    // R7: reset invalidates resident lines and clears counters
    do_reset();
    @(negedge clk_i);
    check(hit_count_o == 0 && miss_count_o == 0, "R7 counters cleared again",
          hit_count_o + miss_count_o, 32'd0);
    do_load(32'h0000_1004, 32'h0000_1004, 0);
    check(l_miss == 1'b1, "R7 line invalid after reset", 32'(l_miss), 32'd1);

    // R9 baseline: two plain streams 16 KB apart thrash
    do_reset();
    for (int w = 0; w < 16; w++) begin
      do_load(32'h0000_8000 + 32'(4 * w), 32'h0000_8000 + 32'(4 * w), 0);
      do_load(32'h0000_C000 + 32'(4 * w), 32'h0000_C000 + 32'(4 * w), 0);
    end
    check(miss_count_o == 32, "R9 conflict misses", miss_count_o, 32'd32);
    check(hit_count_o == 0, "R9 conflict hits", hit_count_o, 32'd0);

    // R9 remapped: second stream placed one line higher
    do_reset();
    for (int w = 0; w < 16; w++) begin
      do_load(32'h0000_8000 + 32'(4 * w), 32'h0000_8000 + 32'(4 * w), 0);
      do_load(32'h0000_C020 + 32'(4 * w), 32'h0000_C000 + 32'(4 * w), 0);
      check(l_data == mem_word(32'h0000_C000 + 32'(4 * w)), "R9 remapped data", l_data,
            mem_word(32'h0000_C000 + 32'(4 * w)));
    end
    check(miss_count_o == 4, "R9 remapped misses", miss_count_o, 32'd4);
    check(hit_count_o == 28, "R9 remapped hits", hit_count_o, 32'd28);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule